// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller built from a parameterized number of 32-pin banks. For each pin it holds an output latch, a direction bit, rising and falling capture enables, a sticky edge flag and an interrupt mask bit. Software changes the output latch only through write-one set and write-one clear registers, so it never needs a read-modify-write. Software acknowledges a captured edge by writing a one to its flag.

The pin inputs are asynchronous. They pass through a two-stage synchronizer before they reach the level readback or the edge detector. A flag reaches the interrupt outputs only where the matching mask bit is one. Pins 0 and 1 each have their own interrupt line. All other pins share one combined line.

The banks are word-interleaved: three banks share each 0x100 window of the address space. A pin range set by parameters has inverted direction polarity.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Bank b sits at base (b/3)*0x100 + (b%3)*4. Its registers sit at these offsets from that base: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge flags 0x48 and mask 0x9C. Bit i of a register belongs to pin b*32+i. Reads of the set register, the clear register and unmapped addresses return zero.
- R2: After reset, the direction, both enable, edge flag, mask and output latch registers all read zero.
- R3: A write to the set register drives high the output latch of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R4: A write to the clear register drives low the output latch of every pin whose data bit is 1. Pins whose data bit is 0 keep their latch value.
- R5: A direction bit of 1 enables the pin's output driver, and 0 disables it. For pins INV_LO..INV_HI (default 86..89) the polarity is reversed, so those drivers are enabled straight after reset.
- R6: A read of the level register returns the synchronized pin value, whatever the pin's direction. A pin change shows there after the second rising clock edge, and not after the first.
- R7: A pin's edge flag sets on a 0-to-1 transition when its rising enable is 1, and on a 1-to-0 transition when its falling enable is 1. The two enables act independently. A set flag stays set until software clears it.
- R8: Writing 1 to a bit of the edge flag register clears that flag. A 0 bit leaves its flag unchanged.
- R9: If a new edge and a clearing write reach the same flag in the same cycle, the flag stays set.
- R10: irq_pin0 and irq_pin1 are the flags of pins 0 and 1 ANDed with their mask bits. irq_mux is the OR of (flag AND mask) over every other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pins_in | input | NUM_BANKS*32 | Asynchronous pin inputs |
| gpio_out | output | NUM_BANKS*32 | Output latch values |
| gpio_oe | output | NUM_BANKS*32 | Output driver enables |
| irq_mux | output | 1 | Combined interrupt for pins 2 and up |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |

## Verification
Register writes take effect at the clock edge on which bus_we is high, so gpio_out, gpio_oe and readback are checked at the falling edge that follows. A pin change is driven at a falling edge. The level read is checked one edge later, where it must still hold the old value, and again after the second rising edge, where it must hold the new one. The edge flags and interrupt lines are checked only after the third rising edge, which is when the flag register loads. The edge-against-clear race is built by placing the clearing write exactly on that third edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned PINS_PER_BANK = 32;
  localparam int unsigned OFF_LEVEL = 'h00;
  localparam int unsigned OFF_DIR   = 'h0C;
  localparam int unsigned OFF_SET   = 'h18;
  localparam int unsigned OFF_CLR   = 'h24;
  localparam int unsigned OFF_RISE  = 'h30;
  localparam int unsigned OFF_FALL  = 'h3C;
  localparam int unsigned OFF_FLAG  = 'h48;
  localparam int unsigned OFF_MASK  = 'h9C;

  function automatic int unsigned bank_base(input int unsigned b);
    return (b / 3) * 'h100 + (b % 3) * 4;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      d_sync <= '0;
    end else begin
      meta_q <= d_async;
      d_sync <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BASE     = 0,
  parameter logic [31:0] INV_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       pin_sync,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [31:0]       out_q,
  output logic [31:0]       oe,
  output logic [31:0]       irq_bits
);
  logic hit_lvl, hit_dir, hit_set, hit_clr, hit_rise, hit_fall, hit_flag, hit_mask;
  logic [31:0] dir_q, rise_q, fall_q, flag_q, mask_q, prev_q;
  logic [31:0] out_d, dir_d, rise_d, fall_d, flag_d, mask_d;
  logic [31:0] edge_hit, w1c;

  assign hit_lvl  = (addr == ADDR_W'(BASE + OFF_LEVEL));
  assign hit_dir  = (addr == ADDR_W'(BASE + OFF_DIR));
  assign hit_set  = (addr == ADDR_W'(BASE + OFF_SET));
  assign hit_clr  = (addr == ADDR_W'(BASE + OFF_CLR));
  assign hit_rise = (addr == ADDR_W'(BASE + OFF_RISE));
  assign hit_fall = (addr == ADDR_W'(BASE + OFF_FALL));
  assign hit_flag = (addr == ADDR_W'(BASE + OFF_FLAG));
  assign hit_mask = (addr == ADDR_W'(BASE + OFF_MASK));

  always_comb begin
    out_d  = out_q;
    if (we && hit_set) out_d = out_q | wdata;
    if (we && hit_clr) out_d = out_q & ~wdata;
    dir_d  = (we && hit_dir)  ? wdata : dir_q;
    rise_d = (we && hit_rise) ? wdata : rise_q;
    fall_d = (we && hit_fall) ? wdata : fall_q;
    mask_d = (we && hit_mask) ? wdata : mask_q;
    edge_hit = (pin_sync & ~prev_q & rise_q) | (~pin_sync & prev_q & fall_q);
    w1c      = (we && hit_flag) ? wdata : '0;
    flag_d   = (flag_q & ~w1c) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      flag_q <= '0;
      mask_q <= '0;
      prev_q <= '0;
    end else begin
      out_q  <= out_d;
      dir_q  <= dir_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
      prev_q <= pin_sync;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_lvl)  rdata = pin_sync;
    if (hit_dir)  rdata = dir_q;
    if (hit_rise) rdata = rise_q;
    if (hit_fall) rdata = fall_q;
    if (hit_flag) rdata = flag_q;
    if (hit_mask) rdata = mask_q;
  end

  assign oe       = dir_q ^ INV_MASK;
  assign irq_bits = flag_q & mask_q;

  // R3
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit_set) |=> ((out_q & $past(wdata)) == $past(wdata)));
  // R4
  clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit_clr) |=> ((out_q & $past(wdata)) == '0));
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && hit_flag) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R9
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit_flag && (edge_hit != '0)) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned INV_LO    = 86,
  parameter int unsigned INV_HI    = 89,
  localparam int unsigned NUM_PINS = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic [NUM_PINS-1:0] gpio_out,
  output logic [NUM_PINS-1:0] gpio_oe,
  output logic                irq_mux,
  output logic                irq_pin0,
  output logic                irq_pin1
);
  function automatic logic [NUM_PINS-1:0] inv_vec();
    logic [NUM_PINS-1:0] v;
    v = '0;
    for (int i = 0; i < int'(NUM_PINS); i++)
      if (i >= int'(INV_LO) && i <= int'(INV_HI)) v[i] = 1'b1;
    return v;
  endfunction
  localparam logic [NUM_PINS-1:0] INV_ALL = inv_vec();

  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  logic [NUM_PINS-1:0] pin_sync, irq_all;
  logic [31:0] bank_rdata [NUM_BANKS];

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_q), .d_async(pins_in), .d_sync(pin_sync));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_edge_bank #(
      .ADDR_W(ADDR_W),
      .BASE(bank_base(b)),
      .INV_MASK(INV_ALL[b*32 +: 32])
    ) u_bank (
      .clk(clk), .rst_n(rst_q),
      .pin_sync(pin_sync[b*32 +: 32]),
      .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
      .rdata(bank_rdata[b]),
      .out_q(gpio_out[b*32 +: 32]),
      .oe(gpio_oe[b*32 +: 32]),
      .irq_bits(irq_all[b*32 +: 32]));
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) bus_rdata = bus_rdata | bank_rdata[b];
  end

  assign irq_pin0 = irq_all[0];
  assign irq_pin1 = irq_all[1];
  assign irq_mux  = |irq_all[NUM_PINS-1:2];

  // R5
  oe_reset_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(rst_q) |-> (gpio_oe == INV_ALL));
endmodule

// File: tb/gpio_edge_ctrl_bench.sv
module gpio_edge_ctrl_bench;
  localparam int NB = 3;
  localparam int NP = NB * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] gpio_out, gpio_oe;
  logic irq_mux, irq_pin0, irq_pin1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_edge_ctrl u_gpio_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pins_in(pins),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq_mux(irq_mux),
    .irq_pin0(irq_pin0), .irq_pin1(irq_pin1));

  function automatic logic [11:0] ra(input int b, input int off);
    return 12'((b / 3) * 256 + (b % 3) * 4 + off);
  endfunction

  function automatic logic [31:0] edge_model(input logic [31:0] o, input logic [31:0] n,
                                             input logic [31:0] r, input logic [31:0] f);
    return (n & ~o & r) | (~n & o & f);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    wait_edges(100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, model, o, n, r, f;
    void'($urandom(32'h5eed));
    wait_edges(3);
    @(negedge clk) rst_n = 1'b1;
    wait_edges(4);

    // R2 reset state
    rd(ra(1, 'h0C), d); check("R2 dir", d, 0);
    rd(ra(1, 'h30), d); check("R2 rise", d, 0);
    rd(ra(1, 'h3C), d); check("R2 fall", d, 0);
    rd(ra(1, 'h48), d); check("R2 flag", d, 0);
    rd(ra(1, 'h9C), d); check("R2 mask", d, 0);
    check("R2 out", gpio_out[63:32], 0);
    // R5 inverted pins drive after reset
    check("R5 oe bank2", gpio_oe[95:64], 32'h03C0_0000);
    check("R5 oe bank0", gpio_oe[31:0], 0);
    wr(ra(2, 'h0C), 32'h0040_0001);
    @(negedge clk);
    check("R5 oe after dir", gpio_oe[95:64], 32'h0380_0001);

    // R1 interleave and unmapped / write-only reads
    wr(ra(0, 'h30), 32'hA5A5_0000);
    wr(ra(1, 'h30), 32'h1234_5678);
    wr(ra(3 - 1, 'h30), 32'h0F0F_0F0F);
    rd(12'h030, d); check("R1 bank0 at 0x30", d, 32'hA5A5_0000);
    rd(12'h034, d); check("R1 bank1 at 0x34", d, 32'h1234_5678);
    rd(12'h038, d); check("R1 bank2 at 0x38", d, 32'h0F0F_0F0F);
    rd(12'h100, d); check("R1 unmapped", d, 0);
    wr(ra(1, 'h18), 32'hFFFF_FFFF);
    rd(ra(1, 'h18), d); check("R1 set reads zero", d, 0);
    wr(ra(1, 'h24), 32'hFFFF_FFFF);
    wr(ra(0, 'h30), 0); wr(ra(1, 'h30), 0); wr(ra(2, 'h30), 0);

    // R3 / R4 random set/clear against a model
    model = 0;
    for (int i = 0; i < 40; i++) begin
      d = $urandom;
      if (i % 2 == 0) begin wr(ra(1, 'h18), d); model = model | d; end
      else begin wr(ra(1, 'h24), d); model = model & ~d; end
      check((i % 2 == 0) ? "R3 set" : "R4 clear", gpio_out[63:32], model);
    end

    // R6 level latency, pin configured as output
    wr(ra(0, 'h0C), 32'h80);
    @(negedge clk) pins[7] = 1'b1;
    bus_addr = ra(0, 0);
    @(posedge clk); @(negedge clk); #1 check("R6 level after one edge", 32'(bus_rdata[7]), 0);
    @(posedge clk); @(negedge clk); #1 check("R6 level after two edges", 32'(bus_rdata[7]), 1);

    // R7 random edges on bank 1
    wait_edges(4);
    for (int i = 0; i < 40; i++) begin
      r = $urandom; f = $urandom;
      wr(ra(1, 'h30), r); wr(ra(1, 'h3C), f);
      wr(ra(1, 'h48), 32'hFFFF_FFFF);
      o = pins[63:32]; n = $urandom;
      @(negedge clk) pins[63:32] = n;
      wait_edges(3);
      rd(ra(1, 'h48), d);
      check("R7 edge flags", d, edge_model(o, n, r, f));
      pins[63:32] = ~n;
      wait_edges(3);
      rd(ra(1, 'h48), d);
      check("R7 sticky plus reverse", d, edge_model(o, n, r, f) | edge_model(n, ~n, r, f));
    end

    // R8 W1C, zero bits ignored
    wr(ra(0, 'h30), 32'h0000_0008);
    @(negedge clk) pins[3] = 1'b1;
    wait_edges(4);
    wr(ra(0, 'h48), 32'h0000_0000);
    rd(ra(0, 'h48), d); check("R8 zero write keeps", d, 32'h8);
    wr(ra(0, 'h48), 32'h0000_0008);
    rd(ra(0, 'h48), d); check("R8 one write clears", d, 0);

    // R9 new edge beats same-cycle clear
    @(negedge clk) pins[3] = 1'b0;
    wait_edges(4);
    wr(ra(0, 'h48), 32'h8);
    @(negedge clk) pins[3] = 1'b1;
    @(posedge clk); @(negedge clk); @(posedge clk);
    @(negedge clk) begin bus_addr = ra(0, 'h48); bus_wdata = 32'h8; bus_we = 1'b1; end
    @(posedge clk);
    @(negedge clk) bus_we = 1'b0;
    rd(ra(0, 'h48), d); check("R9 edge wins", d, 32'h8);
    wr(ra(0, 'h48), 32'hFFFF_FFFF);

    // R10 interrupt gating and routing
    wr(ra(0, 'h30), 32'h0000_0021);
    @(negedge clk) pins[0] = 1'b1;
    wait_edges(4);
    @(negedge clk);
    check("R10 pin0 masked", {irq_mux, irq_pin1, irq_pin0}, 0);
    wr(ra(0, 'h9C), 32'hFFFF_FFFF);
    check("R10 pin0 unmasked", {irq_mux, irq_pin1, irq_pin0}, 3'b001);
    @(negedge clk) pins[5] = 1'b1;
    wait_edges(4);
    @(negedge clk);
    check("R10 mux line", {irq_mux, irq_pin1, irq_pin0}, 3'b101);
    wr(ra(0, 'h48), 32'h0000_0001);
    check("R10 pin0 cleared", {irq_mux, irq_pin1, irq_pin0}, 3'b100);
    wr(ra(0, 'h9C), 32'h0);
    check("R10 mux masked", {irq_mux, irq_pin1, irq_pin0}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule